// File: doc/BRIEF.md
# Boundary scan test access port

This block is a compact test access port for a memory device. A 16-state controller advances on each rising test clock according to the mode-select input, and steers serial data between the test data input and the test data output. Three scan paths sit behind the controller. The first is a 3-bit instruction register. The second is a single-bit bypass stage that shortens the board-level chain. The third is a parameterized boundary register that takes a parallel snapshot of the device pins.

Three instructions are decoded: bypass, sample/preload and external test. Boundary cells that have a pin capture that pin's value. Cells with no pin capture a fixed per-cell default. A separate update stage holds the value shifted in last and exposes it as a parallel output, and that value never reaches the core. The external test instruction does not isolate the core: the core keeps seeing its real pins. All inputs are assumed to be synchronous to the test clock already.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the standard 16-state transition graph, with `tms_i` sampled on each rising `tck_i`. From Run-Test/Idle, the mode-select sequence 1,0,0 enters Shift-DR and the sequence 1,1,0,0 enters Shift-IR.
- R2: Five consecutive rising edges with `tms_i` high reach Test-Logic-Reset from any state. Being in Test-Logic-Reset loads the instruction register with the bypass code.
- R3: While `rst_ni` is low, the controller is in Test-Logic-Reset, the instruction is bypass, `preload_o` is all zeros and `tdo_en_o` is low.
- R4: The instruction register is 3 bits wide and shifts LSB first. Capture-IR loads 3'b001 into it. The new code takes effect on the falling edge in Update-IR. The codes are: 3'b000 external test, 3'b010 sample/preload, 3'b111 bypass. Every other code selects bypass.
- R5: Under bypass, Capture-DR clears the bypass stage, so a DR scan returns 0 first and then returns TDI delayed by one bit.
- R6: Under sample/preload or external test, Capture-DR loads boundary cell i with `pin_i[i]` for i < NUM_PINS. Every other cell i loads bit i of CELL_DEFAULT.
- R7: Under sample/preload or external test, Shift-DR moves the boundary register LSB first from TDI to TDO, one bit per rising edge.
- R8: On the falling edge in Update-DR, `preload_o` takes the shifted boundary contents, but only when the boundary register is selected. It holds its value at all other times, including during bypass DR scans.
- R9: `tdo_o` changes only on falling `tck_i`. `tdo_en_o` is high only in Shift-DR and Shift-IR.
- R10: `core_o` always equals `pin_i`, including while external test is the current instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Mode select |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out, updated on falling edge |
| tdo_en_o | output | 1 | High while a shift state drives `tdo_o` |
| pin_i | input | NUM_PINS | Device pin values seen by capture and core |
| core_o | output | NUM_PINS | Pin values passed to the functional core |
| preload_o | output | BSR_LEN | Boundary update stage contents |

## Verification
The bench builds the block with BSR_LEN = 8, NUM_PINS = 6 and CELL_DEFAULT = 8'h80. This leaves two pinless cells, one with default 1 and one with default 0, so both default polarities appear in every captured word next to live pin bits. An 8-bit DR scan is long enough to show the one-bit delay of the bypass stage and the full LSB-first order of the boundary register. A 3-bit instruction register makes the fixed capture pattern, the unused codes and the all-zero external test code easy to scan in and out.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_state_e;

  localparam int unsigned IR_W = 3;
  localparam logic [IR_W-1:0] IR_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] IR_SAMPLE  = 3'b010;
  localparam logic [IR_W-1:0] IR_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      ST_TLR:    n = m ? ST_TLR    : ST_RTI;
      ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: n = m ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: n = m ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  n = m ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;

  // consecutive high mode-select edges, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)           ones_q <= '0;
    else if (!tms_i)       ones_q <= '0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  // R2
  five_ones_tlr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == 3'd5) |-> (state_q == ST_TLR));

  // R1
  sel_ir_exit_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_SEL_IR && !tms_i) |=> (state_q == ST_CAP_IR));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  output logic       ir_tdo_o,
  output logic       sel_extest_o,
  output logic       sel_sample_o,
  output logic       sel_bypass_o
);

  logic [IR_W-1:0] ir_sh_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_sh_q <= IR_CAPTURE;
    end else begin
      case (state_i)
        ST_CAP_IR: ir_sh_q <= IR_CAPTURE;
        ST_SH_IR:  ir_sh_q <= {tdi_i, ir_sh_q[IR_W-1:1]};
        default:   ;
      endcase
    end
  end

  // active instruction changes on the falling edge only
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                  ir_q <= IR_BYPASS;
    else if (state_i == ST_TLR)   ir_q <= IR_BYPASS;
    else if (state_i == ST_UP_IR) ir_q <= ir_sh_q;
  end

  assign ir_tdo_o     = ir_sh_q[0];
  assign sel_extest_o = (ir_q == IR_EXTEST);
  assign sel_sample_o = (ir_q == IR_SAMPLE);
  assign sel_bypass_o = !(sel_extest_o || sel_sample_o);

  // R2
  ir_bypass_in_tlr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_TLR) |-> (ir_q == IR_BYPASS));

  // R4
  ir_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UP_IR && state_i != ST_TLR) |-> $stable(ir_q));

endmodule

// File: rtl/scan_tap_bsr.sv
module scan_tap_bsr
  import scan_tap_pkg::*;
#(
  parameter int unsigned         BSR_LEN      = 8,
  parameter int unsigned         NUM_PINS     = 6,
  parameter logic [BSR_LEN-1:0]  CELL_DEFAULT = '0
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tdi_i,
  input  tap_state_e          state_i,
  input  logic                sel_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                bsr_tdo_o,
  output logic [BSR_LEN-1:0]  preload_o
);

  logic [BSR_LEN-1:0] cap_vec;
  logic [BSR_LEN-1:0] sh_q;
  logic [BSR_LEN-1:0] upd_q;

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i < NUM_PINS) begin : g_pin
      assign cap_vec[i] = pin_i[i];
    end else begin : g_nopin
      assign cap_vec[i] = CELL_DEFAULT[i];
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (sel_i) begin
      case (state_i)
        ST_CAP_DR: sh_q <= cap_vec;
        ST_SH_DR:  sh_q <= {tdi_i, sh_q[BSR_LEN-1:1]};
        default:   ;
      endcase
    end
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          upd_q <= '0;
    else if (sel_i && state_i == ST_UP_DR) upd_q <= sh_q;
  end

  assign bsr_tdo_o = sh_q[0];
  assign preload_o = upd_q;

  // R8
  preload_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UP_DR || !sel_i) |-> $stable(upd_q));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int unsigned         BSR_LEN      = 8,
  parameter int unsigned         NUM_PINS     = 6,
  parameter logic [BSR_LEN-1:0]  CELL_DEFAULT = '0
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tms_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  output logic                tdo_en_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] core_o,
  output logic [BSR_LEN-1:0]  preload_o
);

  tap_state_e state;
  logic ir_tdo, bsr_tdo;
  logic sel_extest, sel_sample, sel_bypass, sel_bsr;
  logic byp_q;
  logic tdo_d, tdo_q, tdo_en_q;

  scan_tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  scan_tap_ir u_ir (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .tdi_i        (tdi_i),
    .state_i      (state),
    .ir_tdo_o     (ir_tdo),
    .sel_extest_o (sel_extest),
    .sel_sample_o (sel_sample),
    .sel_bypass_o (sel_bypass)
  );

  assign sel_bsr = sel_extest || sel_sample;

  scan_tap_bsr #(
    .BSR_LEN      (BSR_LEN),
    .NUM_PINS     (NUM_PINS),
    .CELL_DEFAULT (CELL_DEFAULT)
  ) u_bsr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .tdi_i     (tdi_i),
    .state_i   (state),
    .sel_i     (sel_bsr),
    .pin_i     (pin_i),
    .bsr_tdo_o (bsr_tdo),
    .preload_o (preload_o)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                              byp_q <= 1'b0;
    else if (state == ST_CAP_DR)              byp_q <= 1'b0;
    else if (state == ST_SH_DR && sel_bypass) byp_q <= tdi_i;
  end

  always_comb begin
    tdo_d = 1'b0;
    if (state == ST_SH_IR)      tdo_d = ir_tdo;
    else if (state == ST_SH_DR) tdo_d = sel_bsr ? bsr_tdo : byp_q;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= (state == ST_SH_DR) || (state == ST_SH_IR);
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = tdo_en_q;
  // core is never isolated, whatever the instruction
  assign core_o   = pin_i;

  // R9
  tdo_en_shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o |-> (state == ST_SH_DR || state == ST_SH_IR));

  // R5
  bypass_first_zero_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_SH_DR && $past(state) == ST_CAP_DR && sel_bypass) |-> (tdo_o == 1'b0));

endmodule

// File: tb/scan_tap_tb_top.sv
module scan_tap_tb_top;

  localparam int unsigned L  = 8;
  localparam int unsigned NP = 6;
  localparam logic [L-1:0] DEF = 8'h80;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [NP-1:0] pins = '0;
  logic tdo, tdo_en;
  logic [NP-1:0] core;
  logic [L-1:0] preload;

  int checks = 0;
  int errors = 0;
  bit en_gap;

  always #4 tck = ~tck;

  scan_tap #(.BSR_LEN(L), .NUM_PINS(NP), .CELL_DEFAULT(DEF)) dut_i (
    .tck_i     (tck),
    .rst_ni    (rst_n),
    .tms_i     (tms),
    .tdi_i     (tdi),
    .tdo_o     (tdo),
    .tdo_en_o  (tdo_en),
    .pin_i     (pins),
    .core_o    (core),
    .preload_o (preload)
  );

  localparam logic [NP+L-1:0] VEC [0:3] = '{
    {6'b101010, 8'h3C},
    {6'b010101, 8'hC3},
    {6'b111111, 8'h00},
    {6'b000000, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic e);
    tms = m;
    tdi = d;
    o = tdo;
    e = tdo_en;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic mv(input logic m);
    logic o, e;
    step(m, 1'b0, o, e);
  endtask

  task automatic shift_ir(input logic [2:0] code, output logic [2:0] cap);
    logic o, e;
    mv(1); mv(1); mv(0); mv(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, e);
      cap[i] = o;
      if (!e) en_gap = 1'b1;
    end
    mv(1); mv(0);
  endtask

  task automatic shift_dr(input logic [L-1:0] din, output logic [L-1:0] dout);
    logic o, e;
    mv(1); mv(0); mv(0);
    for (int i = 0; i < L; i++) begin
      step(i == L - 1, din[i], o, e);
      dout[i] = o;
      if (!e) en_gap = 1'b1;
    end
    mv(1); mv(0);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] cap;
    logic [L-1:0] dout, din, saved;
    logic t0, t1, t2;
    en_gap = 1'b0;

    // reset state
    @(negedge tck); #1;
    @(negedge tck); #1;
    check("R3 tdo_en in reset", {31'd0, tdo_en}, 32'd0);
    check("R3 preload in reset", {24'd0, preload}, 32'd0);
    rst_n = 1'b1;
    mv(0);
    check("R9 tdo_en idle", {31'd0, tdo_en}, 32'd0);
    din = 8'hA5;
    shift_dr(din, dout);
    check("R3 R5 bypass after reset", {24'd0, dout}, {24'd0, din[L-2:0], 1'b0});
    check("R8 preload held under bypass", {24'd0, preload}, 32'd0);

    // instruction capture, sample/preload vector table
    shift_ir(3'b010, cap);
    check("R4 R1 ir capture pattern", {29'd0, cap}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      pins = VEC[k][NP+L-1:L];
      din  = VEC[k][L-1:0];
      #1;
      check("R10 core follows pins", {26'd0, core}, {26'd0, pins});
      shift_dr(din, dout);
      check("R6 R7 sample capture", {24'd0, dout}, {24'd0, DEF[L-1:NP], pins});
      check("R8 preload update", {24'd0, preload}, {24'd0, din});
    end
    check("R9 tdo_en held through shifts", {31'd0, en_gap}, 32'd0);

    // falling-edge TDO, then five high mode-select edges from Shift-DR
    pins = 6'b000001;
    mv(1); mv(0); mv(0);
    t0 = tdo;
    tms = 1'b0; tdi = 1'b0;
    @(posedge tck); #1;
    t1 = tdo;
    @(negedge tck); #1;
    t2 = tdo;
    check("R9 tdo before edge", {31'd0, t0}, 32'd1);
    check("R9 tdo stable after rising edge", {31'd0, t1}, 32'd1);
    check("R9 tdo after falling edge", {31'd0, t2}, 32'd0);
    for (int i = 0; i < 5; i++) mv(1);
    check("R2 tdo_en low in reset state", {31'd0, tdo_en}, 32'd0);
    mv(0);
    saved = preload;
    din = 8'h6E;
    shift_dr(din, dout);
    check("R2 bypass after five ones", {24'd0, dout}, {24'd0, din[L-2:0], 1'b0});
    check("R8 preload unchanged in bypass", {24'd0, preload}, {24'd0, saved});

    // external test: capture and update, core unaffected
    shift_ir(3'b000, cap);
    pins = 6'b110011;
    #1;
    check("R10 core under extest", {26'd0, core}, {26'd0, pins});
    din = 8'h5A;
    shift_dr(din, dout);
    check("R6 R7 extest capture", {24'd0, dout}, {24'd0, DEF[L-1:NP], pins});
    check("R8 extest update", {24'd0, preload}, {24'd0, din});
    pins = 6'b001100;
    #1;
    check("R10 core after extest scan", {26'd0, core}, {26'd0, pins});

    // unused code falls back to bypass
    shift_ir(3'b101, cap);
    check("R4 capture pattern again", {29'd0, cap}, 32'd1);
    din = 8'h93;
    shift_dr(din, dout);
    check("R4 unused code is bypass", {24'd0, dout}, {24'd0, din[L-2:0], 1'b0});
    check("R8 preload held on unused code", {24'd0, preload}, 32'h5A);

    // asynchronous reset mid-session
    shift_ir(3'b010, cap);
    mv(1); mv(0); mv(0);
    rst_n = 1'b0;
    #1;
    check("R3 tdo_en cleared by reset", {31'd0, tdo_en}, 32'd0);
    check("R3 preload cleared by reset", {24'd0, preload}, 32'd0);
    @(negedge tck); #1;
    rst_n = 1'b1;
    mv(0);
    din = 8'h3D;
    shift_dr(din, dout);
    check("R3 bypass after reset pulse", {24'd0, dout}, {24'd0, din[L-2:0], 1'b0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule